// File: doc/BRIEF.md
# Master-Slave One-Shot Trigger Timer

This block pairs two down-counting timer channels to produce a periodic trigger pair, typically used to launch an A/D conversion at a fixed offset inside each period. The master channel is a free-running interval timer. Each time it expires it pulses its interrupt and re-arms the slave channel. The slave then counts out a single delay, pulses its own interrupt once and waits for the next master expiry. The result is a period interrupt followed, after a programmable delay, by a conversion trigger.

Software programs the block through a small register-write port. The writable registers are the period value, the delay value, a control register holding self-clearing start and stop bits, and a rate register for the built-in prescaler. The prescaler divides an incoming base count-enable by one of two fixed ratios. Both counter values and both channel-enable flags are always visible on output ports. A unit enable input acts as a power gate for the whole block.

Top module: `trig_pair_timer`

## Requirements
- R1: While `unit_en` is 0 every register write is ignored and all state is held at its reset value: both counters 0, both enable flags 0, both interrupts 0, period and delay 0, and the rate set to fast. The same values hold after `rst_n` is low at a clock edge.
- R2: A write to address 2 with bit 0 set starts both channels together. From the next cycle both enable flags are 1 and the master counter holds the period value.
- R3: While enabled, the master counter decrements once per count tick. On a tick at count 0 it reloads the period value and raises `irq_master` for exactly one cycle. A period value N therefore gives one master interrupt every N+1 count ticks.
- R4: The slave counter loads the delay value in the cycle after `irq_master` is high, and no tick is consumed in that cycle. It then decrements on each count tick. On a tick at count 0 it raises `irq_slave` for one cycle and stops with the counter at 0. Its enable flag stays 1 while it waits for the next master interrupt.
- R5: If a master interrupt arrives while the slave is still counting, the slave reloads the delay value and restarts. The unfinished count produces no `irq_slave`.
- R6: A write to address 2 with bit 1 set stops both channels. Both enable flags go to 0, both counter values are held unchanged, and no further interrupts occur until the next start.
- R7: When a single control write sets both bit 0 and bit 1, the stop action wins.
- R8: A new period or delay value written while the channels run does not change the count in progress. The master uses it from its next reload, and the slave from its next load.
- R9: A write to address 3 with bit 0 set selects the slow rate, which gives one count tick per `DIV_SLOW` pulses of `base_tick`. Bit 0 clear selects the fast rate, which gives one count tick per `DIV_FAST` pulses.
- R10: Register addresses are 0 for the period, 1 for the delay, 2 for control and 3 for rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| unit_en | input | 1 | Unit enable; 0 holds the block at reset values |
| base_tick | input | 1 | Base count-enable pulse that feeds the prescaler |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | CNT_W | Register write data |
| cnt_master | output | CNT_W | Current master counter value |
| cnt_slave | output | CNT_W | Current slave counter value |
| en_master | output | 1 | Master channel enable flag |
| en_slave | output | 1 | Slave channel enable flag |
| irq_master | output | 1 | Master expiry pulse (period interrupt) |
| irq_slave | output | 1 | Slave expiry pulse (conversion trigger) |

## Verification
The bench goes after the slave retrigger case, where a delay longer than the period means the slave never completes. A design that failed to cancel the unfinished count would emit stray triggers. It also checks a period update made in the middle of an interval, which an eager design would apply at once and so shorten the current interval. Stop is tested both by itself and together with start in the same write: a design that cleared the counters on stop, or let start win, would show the wrong counter values or a live enable flag. The power gate is checked by writing a period while the unit is off and then starting. A design that accepted the write would load that value instead of the reset value 0.

// File: rtl/tpt_pkg.sv
// Shared definitions for the trigger-pair timer: register addresses and
// control bit positions. Assumes a 2-bit register address.
package tpt_pkg;
    typedef enum logic [1:0] {
        ADR_PERIOD = 2'd0,
        ADR_DELAY  = 2'd1,
        ADR_CTRL   = 2'd2,
        ADR_RATE   = 2'd3
    } tpt_addr_e;

    localparam int CTRL_START_BIT = 0;
    localparam int CTRL_STOP_BIT  = 1;
    localparam int RATE_SLOW_BIT  = 0;
endpackage

// File: rtl/tpt_prescaler.sv
// Count-enable prescaler. Divides base_tick_i by DIV_FAST or DIV_SLOW,
// chosen by slow_i. Assumes both ratios are at least 1. A ratio change
// mid-count resolves at the next base pulse.
module tpt_prescaler #(
    parameter int DIV_FAST = 1,
    parameter int DIV_SLOW = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic base_tick_i,
    input  logic slow_i,
    output logic tick_o
);
    localparam int DMAX = (DIV_SLOW > DIV_FAST) ? DIV_SLOW : DIV_FAST;
    localparam int PW   = ($clog2(DMAX) > 0) ? $clog2(DMAX) : 1;

    logic [PW-1:0] pc_q;
    logic [PW-1:0] lim;

    // Terminal count for the selected ratio.
    generate
        if (DIV_FAST == DIV_SLOW) begin : g_single
            assign lim = PW'(DIV_FAST - 1);
        end else begin : g_dual
            assign lim = slow_i ? PW'(DIV_SLOW - 1) : PW'(DIV_FAST - 1);
        end
    endgenerate

    assign tick_o = base_tick_i && (pc_q >= lim);

    // Base-pulse counter, wraps on each emitted tick.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            pc_q <= '0;
        end else if (base_tick_i) begin
            pc_q <= (pc_q >= lim) ? '0 : pc_q + 1'b1;
        end
    end

    AST_PRE_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!base_tick_i && !clr_i) |=> $stable(pc_q)) else $error("prescaler moved without base tick"); // R9
endmodule

// File: rtl/tpt_master_ch.sv
// Master channel: free-running down counter. It loads the period on start
// and on every expiry, and pulses irq_o for one cycle at each expiry.
// Assumes tick_i is a single-cycle enable and that stop outranks start.
module tpt_master_ch #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             tick_i,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic [CNT_W-1:0] period_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             en_o,
    output logic             irq_o
);
    logic [CNT_W-1:0] cnt_q;
    logic             en_q;
    logic             irq_q;

    // Count, reload and expiry pulse generation.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cnt_q <= '0;
            en_q  <= 1'b0;
            irq_q <= 1'b0;
        end else if (stop_i) begin
            en_q  <= 1'b0;
            irq_q <= 1'b0;
        end else if (start_i) begin
            en_q  <= 1'b1;
            cnt_q <= period_i;
            irq_q <= 1'b0;
        end else if (en_q && tick_i) begin
            if (cnt_q == '0) begin
                cnt_q <= period_i;
                irq_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q - 1'b1;
                irq_q <= 1'b0;
            end
        end else begin
            irq_q <= 1'b0;
        end
    end

    assign cnt_o = cnt_q;
    assign en_o  = en_q;
    assign irq_o = irq_q;

    AST_M_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && tick_i && cnt_q != '0 && !start_i && !stop_i && !clr_i)
        |=> (cnt_q == $past(cnt_q) - 1'b1 && !irq_q)) else $error("master decrement"); // R3
    AST_M_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !start_i && !clr_i) |=> ($stable(cnt_q) && !irq_q)) else $error("master moved while stopped"); // R6
    AST_M_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !clr_i) |=> (!en_q && !irq_q)) else $error("stop did not halt master"); // R7
endmodule

// File: rtl/tpt_slave_ch.sv
// Slave channel: one-shot down counter. It is armed by the master expiry
// pulse, counts the delay once, pulses irq_o and halts. Assumes trig_i is
// the registered master interrupt; a retrigger mid-count restarts silently.
module tpt_slave_ch #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             tick_i,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             trig_i,
    input  logic [CNT_W-1:0] delay_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             en_o,
    output logic             irq_o
);
    logic [CNT_W-1:0] cnt_q;
    logic             en_q;
    logic             run_q;
    logic             irq_q;

    // Load on master pulse, count once, flag expiry.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cnt_q <= '0;
            en_q  <= 1'b0;
            run_q <= 1'b0;
            irq_q <= 1'b0;
        end else if (stop_i) begin
            en_q  <= 1'b0;
            run_q <= 1'b0;
            irq_q <= 1'b0;
        end else if (start_i) begin
            en_q  <= 1'b1;
            run_q <= 1'b0;
            irq_q <= 1'b0;
        end else if (en_q && trig_i) begin
            cnt_q <= delay_i;
            run_q <= 1'b1;
            irq_q <= 1'b0;
        end else if (run_q && tick_i) begin
            if (cnt_q == '0) begin
                run_q <= 1'b0;
                irq_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q - 1'b1;
                irq_q <= 1'b0;
            end
        end else begin
            irq_q <= 1'b0;
        end
    end

    assign cnt_o = cnt_q;
    assign en_o  = en_q;
    assign irq_o = irq_q;

    AST_S_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_i && en_q && !start_i && !stop_i && !clr_i)
        |=> (run_q && cnt_q == $past(delay_i))) else $error("slave load"); // R4
    AST_S_IRQ_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> (!run_q && cnt_q == '0)) else $error("slave pulse while counting"); // R4
    AST_S_RETRIG_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_i && run_q && en_q && !start_i && !stop_i && !clr_i) |=> !irq_q) else $error("retrigger pulsed"); // R5
endmodule

// File: rtl/trig_pair_timer.sv
// Top of the trigger-pair timer: the register-write decode, the prescaler and
// the two coupled channels. Assumes writes are single-cycle strobes. unit_en
// low holds everything at reset values.
module trig_pair_timer
    import tpt_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int DIV_FAST = 1,
    parameter int DIV_SLOW = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             unit_en,
    input  logic             base_tick,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] cnt_master,
    output logic [CNT_W-1:0] cnt_slave,
    output logic             en_master,
    output logic             en_slave,
    output logic             irq_master,
    output logic             irq_slave
);
    logic [CNT_W-1:0] period_q;
    logic [CNT_W-1:0] delay_q;
    logic             slow_q;
    logic             wr_ok;
    logic             start_req;
    logic             stop_req;
    logic             tick;
    logic             clr;
    tpt_addr_e        adr;

    assign clr       = !unit_en;
    assign wr_ok     = wr_en && unit_en;
    assign adr       = tpt_addr_e'(wr_addr);
    assign start_req = wr_ok && (adr == ADR_CTRL) && wr_data[CTRL_START_BIT];
    assign stop_req  = wr_ok && (adr == ADR_CTRL) && wr_data[CTRL_STOP_BIT];

    // Configuration registers, gated by the unit enable.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            period_q <= '0;
            delay_q  <= '0;
            slow_q   <= 1'b0;
        end else if (wr_ok) begin
            case (adr)
                ADR_PERIOD: period_q <= wr_data;
                ADR_DELAY:  delay_q  <= wr_data;
                ADR_RATE:   slow_q   <= wr_data[RATE_SLOW_BIT];
                default:    ;
            endcase
        end
    end

    tpt_prescaler #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) pre_i (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .base_tick_i(base_tick),
        .slow_i(slow_q), .tick_o(tick)
    );

    tpt_master_ch #(.CNT_W(CNT_W)) mst_i (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .tick_i(tick),
        .start_i(start_req), .stop_i(stop_req), .period_i(period_q),
        .cnt_o(cnt_master), .en_o(en_master), .irq_o(irq_master)
    );

    tpt_slave_ch #(.CNT_W(CNT_W)) slv_i (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .tick_i(tick),
        .start_i(start_req), .stop_i(stop_req), .trig_i(irq_master),
        .delay_i(delay_q), .cnt_o(cnt_slave), .en_o(en_slave), .irq_o(irq_slave)
    );

    AST_GATE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !unit_en |=> (cnt_master == '0 && cnt_slave == '0 && !en_master && !en_slave
                      && !irq_master && !irq_slave)) else $error("gate off not reset"); // R1
    AST_START_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        (start_req && !stop_req) |=> (en_master && en_slave)) else $error("start not joint"); // R2
endmodule

// File: tb/trig_pair_timer_tb_top.sv
`timescale 1ns/1ps
module trig_pair_timer_tb_top;
    localparam int W = 16;
    localparam int DF = 1;
    localparam int DS = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         unit_en = 1'b0;
    logic         base_tick = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_addr = '0;
    logic [W-1:0] wr_data = '0;
    logic [W-1:0] cnt_master, cnt_slave;
    logic         en_master, en_slave, irq_master, irq_slave;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // reference state
    logic [W-1:0] m_per, m_dly, m_mc, m_sc;
    logic         m_rsel, m_me, m_se, m_srun, m_mi, m_si;
    int           m_pc;

    always #2 clk = ~clk;

    trig_pair_timer #(.CNT_W(W), .DIV_FAST(DF), .DIV_SLOW(DS)) dut_i (
        .clk(clk), .rst_n(rst_n), .unit_en(unit_en), .base_tick(base_tick),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cnt_master(cnt_master), .cnt_slave(cnt_slave), .en_master(en_master),
        .en_slave(en_slave), .irq_master(irq_master), .irq_slave(irq_slave)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Reference update at a clock edge, from the requirements.
    task automatic model_step();
        logic tk, st, sp, mi_old;
        int lim;
        if (!rst_n || !unit_en) begin
            m_per = 0; m_dly = 0; m_mc = 0; m_sc = 0; m_rsel = 0; m_me = 0;
            m_se = 0; m_srun = 0; m_mi = 0; m_si = 0; m_pc = 0;
            return;
        end
        lim = m_rsel ? DS - 1 : DF - 1;
        tk = base_tick && (m_pc >= lim);
        if (base_tick) m_pc = (m_pc >= lim) ? 0 : m_pc + 1;
        st = wr_en && wr_addr == 2'd2 && wr_data[0];
        sp = wr_en && wr_addr == 2'd2 && wr_data[1];
        mi_old = m_mi;
        if (sp) begin m_me = 0; m_mi = 0; end
        else if (st) begin m_me = 1; m_mc = m_per; m_mi = 0; end
        else if (m_me && tk) begin
            if (m_mc == 0) begin m_mc = m_per; m_mi = 1; end
            else begin m_mc = m_mc - 1; m_mi = 0; end
        end else m_mi = 0;
        if (sp) begin m_se = 0; m_srun = 0; m_si = 0; end
        else if (st) begin m_se = 1; m_srun = 0; m_si = 0; end
        else if (m_se && mi_old) begin m_sc = m_dly; m_srun = 1; m_si = 0; end
        else if (m_srun && tk) begin
            if (m_sc == 0) begin m_srun = 0; m_si = 1; end
            else begin m_sc = m_sc - 1; m_si = 0; end
        end else m_si = 0;
        if (wr_en) begin
            if (wr_addr == 2'd0) m_per = wr_data;
            if (wr_addr == 2'd1) m_dly = wr_data;
            if (wr_addr == 2'd3) m_rsel = wr_data[0];
        end
    endtask

    // One clock: reference update at the edge, compare at the falling edge.
    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk("R3", "cnt_master", cnt_master, m_mc);
        chk("R3", "irq_master", irq_master, m_mi);
        chk("R4", "cnt_slave", cnt_slave, m_sc);
        chk("R4", "irq_slave", irq_slave, m_si);
        chk("R2", "en_master", en_master, m_me);
        chk("R2", "en_slave", en_slave, m_se);
    endtask

    task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
        cyc();
        wr_en = 0; wr_data = '0;
    endtask

    // Cycles until a pulse on the selected interrupt, 0 if none in lim.
    task automatic wait_irq(input bit slave, input int lim, output int n);
        n = 0;
        for (int i = 1; i <= lim; i++) begin
            cyc();
            if ((slave ? irq_slave : irq_master) == 1'b1) begin n = i; return; end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=expired expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int n, cnt_sv, pulses;
        m_pc = 0;
        rst_n = 0; unit_en = 1;
        cyc(); cyc();
        rst_n = 1;
        // R1: reset state
        chk("R1", "reset cnt_master", cnt_master, 0);
        chk("R1", "reset en_master", en_master, 0);
        chk("R1", "reset irq_slave", irq_slave, 0);

        base_tick = 1;
        wr(2'd0, 16'd3);
        wr(2'd1, 16'd1);
        wr(2'd2, 16'h1);
        // R10 / R2: period from address 0 is loaded on start
        chk("R10", "loaded period", cnt_master, 3);
        chk("R2", "en both", {en_master, en_slave}, 3);
        // R3: interval of N+1 ticks
        wait_irq(0, 50, n);
        wait_irq(0, 50, n);
        chk("R3", "master interval", n, 4);
        // R4: slave pulse after load plus N+1 ticks, then halted at 0
        wait_irq(1, 50, n);
        chk("R4", "slave delay", n, 3);
        cyc();
        chk("R4", "slave halted cnt", cnt_slave, 0);
        chk("R4", "slave still enabled", en_slave, 1);
        // R8: period update mid-interval takes effect next reload
        wait_irq(0, 50, n);
        wr(2'd0, 16'd7);
        wait_irq(0, 50, n);
        chk("R8", "old interval kept", n + 1, 4);
        wait_irq(0, 50, n);
        chk("R8", "new interval", n, 8);
        // R5: delay longer than period, slave never completes
        wr(2'd0, 16'd3);
        wr(2'd1, 16'd9);
        wait_irq(0, 50, n);
        wait_irq(0, 50, n);
        pulses = 0;
        for (int i = 0; i < 40; i++) begin cyc(); if (irq_slave) pulses++; end
        chk("R5", "retrigger pulses", pulses, 0);
        // R6: stop holds counters
        wr(2'd2, 16'h2);
        cnt_sv = cnt_master;
        for (int i = 0; i < 10; i++) cyc();
        chk("R6", "held cnt_master", cnt_master, cnt_sv);
        chk("R6", "en after stop", {en_master, en_slave}, 0);
        // R7: start plus stop together
        wr(2'd2, 16'h3);
        chk("R7", "stop wins idle", en_master, 0);
        wr(2'd2, 16'h1);
        wr(2'd2, 16'h3);
        chk("R7", "stop wins running", {en_master, en_slave}, 0);
        // R9: slow rate
        wr(2'd3, 16'h1);
        wr(2'd1, 16'd1);
        wr(2'd2, 16'h1);
        wait_irq(0, 100, n);
        wait_irq(0, 100, n);
        chk("R9", "slow interval", n, 4 * DS);
        wr(2'd3, 16'h0);
        wait_irq(0, 100, n);
        wait_irq(0, 100, n);
        chk("R9", "fast interval", n, 4 * DF);
        // R1: power gate ignores writes and clears state
        unit_en = 0;
        cyc();
        chk("R1", "gated en", {en_master, en_slave}, 0);
        wr(2'd0, 16'd9);
        unit_en = 1;
        wr(2'd2, 16'h1);
        chk("R1", "period stayed reset", cnt_master, 0);

        // Constrained random with a fixed seed
        void'($urandom(32'd1234));
        for (int i = 0; i < 30000; i++) begin
            base_tick = ($urandom % 4) != 0;
            unit_en = ($urandom % 500) != 0;
            if (($urandom % 12) == 0) begin
                wr_en = 1;
                wr_addr = 2'($urandom % 4);
                wr_data = (wr_addr == 2'd2) ? W'(($urandom % 8 == 0) ? 3 : 1 + ($urandom % 2))
                        : W'($urandom % 12);
            end else begin
                wr_en = 0;
            end
            cyc();
        end
        wr_en = 0;
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule